// File: doc/BRIEF.md
# Pixel-Count Display Timing Generator

This block produces the horizontal sync, vertical sync and data-enable timing for a video output. Every vertical event is set as an absolute count of pixel clocks from the start of the frame, not as a line number. The frame is therefore one long pixel counter. The vertical total, the vsync width and the display start and end are all positions on that counter. A horizontal position counter runs alongside it. An hsync skew shifts where lines begin relative to the frame start.

Software programs the block through a simple word-write port. The fields are the line period, the sync widths, a display window, an optional active sub-window, the skew, the output polarities, a border colour and an underflow colour. A pixel mux drives one of three values: the incoming pixel, the border colour for positions inside the display window but outside the sub-window, or the underflow colour when upstream data is missing. The block also reports a running line count, a frame count and a one-cycle frame-start pulse. A frame-length update can be staged with a hold flag so that it takes effect cleanly. All other settings are shadowed and take effect only at a frame boundary.

Top module: `pxtg_top`

## Requirements
- R1: Writes with `wr_en` high land on the register selected by `wr_addr`:
  - 0: line period in [30:16] and hsync width in [14:0].
  - 1: frame period in pixel clocks in [22:0], with a hold flag in bit 23.
  - 2: vsync width in pixel clocks.
  - 3: display horizontal start in [14:0] and end in [30:16].
  - 4 and 5: display vertical start and end, as pixel counts.
  - 6: sub-window horizontal enable in bit 31, start in [14:0] and end in [30:16].
  - 7: sub-window vertical enable in bit 31 and start in [22:0].
  - 8: sub-window vertical end.
  - 9: skew.
  - 10: polarity.
  - 11: border colour.
  - 12: underflow colour.
  - 13: counter enable, where bit 0 enables the line count and bit 1 enables the frame count.
  - 14: engine enable in bit 0.
- R2: While enabled, the frame counter steps by one each clock and returns to 0 after (period − 1). `frame_start` is high for exactly the cycles in which the frame counter is 0.
- R3: At frame start the horizontal position loads (line period − skew), or 0 when the skew is 0. It returns to 0 after (line period − 1) and increments the line count each time it does so. The line count is cleared at frame start. `line_count` reads 0 while counter-enable bit 0 is clear. `frame_count` advances at each frame wrap while counter-enable bit 1 is set.
- R4: Raw hsync is active while the horizontal position is below the hsync width. Raw vsync is active while the frame counter is below the vsync width.
- R5: Raw data enable is active when the frame counter lies within [vertical start, vertical end] and the horizontal position lies within [horizontal start, horizontal end], both ranges inclusive.
- R6: Each axis of the sub-window applies only when its bit-31 enable is set. A pixel inside the display window but outside an enabled sub-window range drives the border colour, and `pix_req` stays low for it.
- R7: Inside the active area `pix_out` is `pix_in` when `pix_valid` is high. Otherwise it is the underflow colour, and `underflow` is high. Outside the display window `pix_out` is 0.
- R8: Polarity bit 0 inverts hsync, bit 1 inverts vsync and bit 2 inverts data enable.
- R9: While the engine enable is clear, the following all stay inactive: raw syncs, data enable, `pix_req`, `pix_out` and `frame_start`, and the line and frame counts are held at 0. Setting the enable starts a frame: `frame_start` is high in the first cycle after the write.
- R10: All settings except the frame period, the counter enable and the engine enable are copied into working copies only at a frame wrap or while the engine is off. A write in the middle of a frame does not change that frame.
- R11: A frame-period write with bit 23 set leaves the running period unchanged. A write with bit 23 clear takes effect at once.
- R12: After reset all outputs are low and both counts read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register select |
| wr_data | input | 32 | Register write data |
| pix_in | input | COL_W | Upstream pixel value |
| pix_valid | input | 1 | Upstream pixel available |
| hsync | output | 1 | Horizontal sync after polarity |
| vsync | output | 1 | Vertical sync after polarity |
| de | output | 1 | Data enable after polarity |
| pix_req | output | 1 | Upstream pixel consumed this cycle |
| pix_out | output | COL_W | Pixel driven to the output |
| underflow | output | 1 | Active pixel with no upstream data |
| frame_start | output | 1 | Frame counter at 0 while enabled |
| line_count | output | LINE_W | Lines completed in the current frame |
| frame_count | output | LINE_W | Frames completed since enable |

## Verification
The embedded properties check the following on every cycle:
- the frame counter either steps by one or returns to 0;
- the line count clears and the horizontal position reloads after each wrap;
- a held period write leaves the running period untouched;
- the working copies stay frozen between frame boundaries;
- an idle engine emits nothing;
- an underflow always shows the underflow colour.

Only the bench's scenarios can show that the window edges, the sub-window border, the skewed line phase and the polarity inversions land on the right pixel counts. The same applies to the three-write period sequence changing the measured frame length, and to a mid-frame write being deferred to the next frame. The bench compares every output against a behavioural model on every clock.

// File: rtl/pxtg_pkg.sv
package pxtg_pkg;

   typedef enum logic [3:0] {
      A_HCTL  = 4'd0,
      A_VPER  = 4'd1,
      A_VSW   = 4'd2,
      A_DISPH = 4'd3,
      A_DVS   = 4'd4,
      A_DVE   = 4'd5,
      A_ACTH  = 4'd6,
      A_AVS   = 4'd7,
      A_AVE   = 4'd8,
      A_SKEW  = 4'd9,
      A_POL   = 4'd10,
      A_BORD  = 4'd11,
      A_UFCOL = 4'd12,
      A_CNTEN = 4'd13,
      A_TGEN  = 4'd14
   } reg_addr_e;

   localparam int ADDR_W     = 4;
   localparam int DATA_W     = 32;
   localparam int HOLD_BIT   = 23;
   localparam int ACT_EN_BIT = 31;
   localparam int HI_LSB     = 16;
   localparam int POL_HS     = 0;
   localparam int POL_VS     = 1;
   localparam int POL_DE     = 2;

endpackage

// File: rtl/pxtg_regs.sv
module pxtg_regs
   import pxtg_pkg::*;
#(
   parameter int H_W   = 15,
   parameter int CNT_W = 23,
   parameter int COL_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              frame_load,
   output logic              tg_en,
   output logic [1:0]        cnt_en,
   output logic [CNT_W-1:0]  per,
   output logic [H_W-1:0]    pr_hper,
   output logic [H_W-1:0]    pr_skew,
   output logic [H_W-1:0]    sh_hper,
   output logic [H_W-1:0]    sh_hsw,
   output logic [H_W-1:0]    sh_dhs,
   output logic [H_W-1:0]    sh_dhe,
   output logic [CNT_W-1:0]  sh_vsw,
   output logic [CNT_W-1:0]  sh_dvs,
   output logic [CNT_W-1:0]  sh_dve,
   output logic              sh_ahen,
   output logic [H_W-1:0]    sh_ahs,
   output logic [H_W-1:0]    sh_ahe,
   output logic              sh_aven,
   output logic [CNT_W-1:0]  sh_avs,
   output logic [CNT_W-1:0]  sh_ave,
   output logic [2:0]        sh_pol,
   output logic [COL_W-1:0]  sh_bord,
   output logic [COL_W-1:0]  sh_uf
);

   logic [H_W-1:0]   p_hsw, p_dhs, p_dhe, p_ahs, p_ahe;
   logic [CNT_W-1:0] p_vsw, p_dvs, p_dve, p_avs, p_ave;
   logic             p_ahen, p_aven;
   logic [2:0]       p_pol;
   logic [COL_W-1:0] p_bord, p_uf;
   logic             unused_wr_bits;

   assign unused_wr_bits = ^wr_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tg_en   <= 1'b0;
         cnt_en  <= '0;
         per     <= '0;
         pr_hper <= '0;
         pr_skew <= '0;
         p_hsw   <= '0;
         p_dhs   <= '0;
         p_dhe   <= '0;
         p_vsw   <= '0;
         p_dvs   <= '0;
         p_dve   <= '0;
         p_ahen  <= 1'b0;
         p_ahs   <= '0;
         p_ahe   <= '0;
         p_aven  <= 1'b0;
         p_avs   <= '0;
         p_ave   <= '0;
         p_pol   <= '0;
         p_bord  <= '0;
         p_uf    <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            A_HCTL: begin
               pr_hper <= wr_data[HI_LSB +: H_W];
               p_hsw   <= wr_data[0 +: H_W];
            end
            A_VPER:  if (!wr_data[HOLD_BIT]) per <= wr_data[CNT_W-1:0];
            A_VSW:   p_vsw <= wr_data[CNT_W-1:0];
            A_DISPH: begin
               p_dhs <= wr_data[0 +: H_W];
               p_dhe <= wr_data[HI_LSB +: H_W];
            end
            A_DVS:   p_dvs <= wr_data[CNT_W-1:0];
            A_DVE:   p_dve <= wr_data[CNT_W-1:0];
            A_ACTH: begin
               p_ahen <= wr_data[ACT_EN_BIT];
               p_ahs  <= wr_data[0 +: H_W];
               p_ahe  <= wr_data[HI_LSB +: H_W];
            end
            A_AVS: begin
               p_aven <= wr_data[ACT_EN_BIT];
               p_avs  <= wr_data[CNT_W-1:0];
            end
            A_AVE:   p_ave   <= wr_data[CNT_W-1:0];
            A_SKEW:  pr_skew <= wr_data[0 +: H_W];
            A_POL:   p_pol   <= wr_data[2:0];
            A_BORD:  p_bord  <= wr_data[COL_W-1:0];
            A_UFCOL: p_uf    <= wr_data[COL_W-1:0];
            A_CNTEN: cnt_en  <= wr_data[1:0];
            A_TGEN:  tg_en   <= wr_data[0];
            default: ;
         endcase
      end
   end

   // working copies, refreshed only at a frame boundary or while idle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_hper <= '0;
         sh_hsw  <= '0;
         sh_dhs  <= '0;
         sh_dhe  <= '0;
         sh_vsw  <= '0;
         sh_dvs  <= '0;
         sh_dve  <= '0;
         sh_ahen <= 1'b0;
         sh_ahs  <= '0;
         sh_ahe  <= '0;
         sh_aven <= 1'b0;
         sh_avs  <= '0;
         sh_ave  <= '0;
         sh_pol  <= '0;
         sh_bord <= '0;
         sh_uf   <= '0;
      end else if (frame_load) begin
         sh_hper <= pr_hper;
         sh_hsw  <= p_hsw;
         sh_dhs  <= p_dhs;
         sh_dhe  <= p_dhe;
         sh_vsw  <= p_vsw;
         sh_dvs  <= p_dvs;
         sh_dve  <= p_dve;
         sh_ahen <= p_ahen;
         sh_ahs  <= p_ahs;
         sh_ahe  <= p_ahe;
         sh_aven <= p_aven;
         sh_avs  <= p_avs;
         sh_ave  <= p_ave;
         sh_pol  <= p_pol;
         sh_bord <= p_bord;
         sh_uf   <= p_uf;
      end
   end

   // R11
   hold_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == A_VPER && wr_data[HOLD_BIT]) |=> $stable(per));

   // R10
   shadow_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_load |=> $stable({sh_hper, sh_hsw, sh_dhs, sh_dhe, sh_vsw, sh_dvs,
                               sh_dve, sh_ahen, sh_ahs, sh_ahe, sh_aven, sh_avs,
                               sh_ave, sh_pol, sh_bord, sh_uf}));

endmodule

// File: rtl/pxtg_counters.sv
module pxtg_counters #(
   parameter int H_W    = 15,
   parameter int CNT_W  = 23,
   parameter int LINE_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tg_en,
   input  logic              count_frames,
   input  logic [CNT_W-1:0]  per,
   input  logic [H_W-1:0]    sh_hper,
   input  logic [H_W-1:0]    pr_hper,
   input  logic [H_W-1:0]    pr_skew,
   output logic [CNT_W-1:0]  fcnt,
   output logic [H_W-1:0]    hcnt,
   output logic [LINE_W-1:0] line_q,
   output logic [LINE_W-1:0] frames_q,
   output logic              frame_load,
   output logic              frame_start
);

   logic [CNT_W:0] f_inc;
   logic [H_W:0]   h_inc;
   logic           f_wrap, h_wrap;
   logic [H_W-1:0] h_reload;

   assign f_inc       = {1'b0, fcnt} + 1'b1;
   assign h_inc       = {1'b0, hcnt} + 1'b1;
   assign f_wrap      = f_inc >= {1'b0, per};
   assign h_wrap      = h_inc >= {1'b0, sh_hper};
   assign h_reload    = (pr_skew == '0) ? '0 : (pr_hper - pr_skew);
   assign frame_load  = !tg_en || f_wrap;
   assign frame_start = tg_en && (fcnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fcnt     <= '0;
         hcnt     <= '0;
         line_q   <= '0;
         frames_q <= '0;
      end else if (!tg_en) begin
         fcnt     <= '0;
         hcnt     <= h_reload;
         line_q   <= '0;
         frames_q <= '0;
      end else if (f_wrap) begin
         fcnt   <= '0;
         hcnt   <= h_reload;
         line_q <= '0;
         if (count_frames) frames_q <= frames_q + 1'b1;
      end else begin
         fcnt <= f_inc[CNT_W-1:0];
         if (h_wrap) begin
            hcnt   <= '0;
            line_q <= line_q + 1'b1;
         end else begin
            hcnt <= h_inc[H_W-1:0];
         end
      end
   end

   // R2
   frame_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tg_en |=> (fcnt == '0 || fcnt == $past(fcnt) + CNT_W'(1)));

   // R3
   line_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tg_en && f_wrap) |=> (line_q == '0 && hcnt == $past(h_reload)));

endmodule

// File: rtl/pxtg_window.sv
module pxtg_window
   import pxtg_pkg::*;
#(
   parameter int H_W        = 15,
   parameter int CNT_W      = 23,
   parameter int COL_W      = 24,
   parameter bit HAS_SUBWIN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tg_en,
   input  logic [CNT_W-1:0]  fcnt,
   input  logic [H_W-1:0]    hcnt,
   input  logic [H_W-1:0]    sh_hsw,
   input  logic [H_W-1:0]    sh_dhs,
   input  logic [H_W-1:0]    sh_dhe,
   input  logic [CNT_W-1:0]  sh_vsw,
   input  logic [CNT_W-1:0]  sh_dvs,
   input  logic [CNT_W-1:0]  sh_dve,
   input  logic              sh_ahen,
   input  logic [H_W-1:0]    sh_ahs,
   input  logic [H_W-1:0]    sh_ahe,
   input  logic              sh_aven,
   input  logic [CNT_W-1:0]  sh_avs,
   input  logic [CNT_W-1:0]  sh_ave,
   input  logic [2:0]        sh_pol,
   input  logic [COL_W-1:0]  sh_bord,
   input  logic [COL_W-1:0]  sh_uf,
   input  logic [COL_W-1:0]  pix_in,
   input  logic              pix_valid,
   output logic              hsync,
   output logic              vsync,
   output logic              de,
   output logic              pix_req,
   output logic [COL_W-1:0]  pix_out,
   output logic              underflow
);

   logic hs_raw, vs_raw, in_h, in_v, disp, act_ok;

   assign hs_raw = tg_en && (hcnt < sh_hsw);
   assign vs_raw = tg_en && (fcnt < sh_vsw);
   assign in_h   = (hcnt >= sh_dhs) && (hcnt <= sh_dhe);
   assign in_v   = (fcnt >= sh_dvs) && (fcnt <= sh_dve);
   assign disp   = tg_en && in_h && in_v;

   generate
      if (HAS_SUBWIN) begin : g_subwin
         logic h_ok, v_ok;
         assign h_ok   = !sh_ahen || ((hcnt >= sh_ahs) && (hcnt <= sh_ahe));
         assign v_ok   = !sh_aven || ((fcnt >= sh_avs) && (fcnt <= sh_ave));
         assign act_ok = h_ok && v_ok;
      end else begin : g_full
         logic unused_subwin;
         assign unused_subwin = ^{sh_ahen, sh_ahs, sh_ahe, sh_aven, sh_avs, sh_ave};
         assign act_ok = 1'b1;
      end
   endgenerate

   always_comb begin
      if (!disp)          pix_out = '0;
      else if (!act_ok)   pix_out = sh_bord;
      else if (pix_valid) pix_out = pix_in;
      else                pix_out = sh_uf;
   end

   assign pix_req   = disp && act_ok;
   assign underflow = pix_req && !pix_valid;
   assign hsync     = hs_raw ^ sh_pol[POL_HS];
   assign vsync     = vs_raw ^ sh_pol[POL_VS];
   assign de        = disp ^ sh_pol[POL_DE];

   // R7
   uf_colour_chk: assert property (@(posedge clk) disable iff (!rst_n)
      underflow |-> (pix_out == sh_uf && !pix_valid));

endmodule

// File: rtl/pxtg_top.sv
module pxtg_top
   import pxtg_pkg::*;
#(
   parameter int H_W        = 15,
   parameter int CNT_W      = 23,
   parameter int COL_W      = 24,
   parameter int LINE_W     = 16,
   parameter bit HAS_SUBWIN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [3:0]        wr_addr,
   input  logic [31:0]       wr_data,
   input  logic [COL_W-1:0]  pix_in,
   input  logic              pix_valid,
   output logic              hsync,
   output logic              vsync,
   output logic              de,
   output logic              pix_req,
   output logic [COL_W-1:0]  pix_out,
   output logic              underflow,
   output logic              frame_start,
   output logic [LINE_W-1:0] line_count,
   output logic [LINE_W-1:0] frame_count
);

   generate
      if (H_W < 2 || H_W > 15) begin : g_bad_hw
         $error("pxtg_top: H_W must lie in 2..15");
      end
      if (CNT_W < H_W || CNT_W > HOLD_BIT) begin : g_bad_cw
         $error("pxtg_top: CNT_W must lie in H_W..23");
      end
      if (COL_W < 1 || COL_W > DATA_W) begin : g_bad_col
         $error("pxtg_top: COL_W must lie in 1..32");
      end
      if (LINE_W < 2 || LINE_W > 32) begin : g_bad_line
         $error("pxtg_top: LINE_W must lie in 2..32");
      end
   endgenerate

   logic              tg_en, frame_load;
   logic [1:0]        cnt_en;
   logic [CNT_W-1:0]  per, fcnt;
   logic [H_W-1:0]    pr_hper, pr_skew, hcnt;
   logic [H_W-1:0]    sh_hper, sh_hsw, sh_dhs, sh_dhe, sh_ahs, sh_ahe;
   logic [CNT_W-1:0]  sh_vsw, sh_dvs, sh_dve, sh_avs, sh_ave;
   logic              sh_ahen, sh_aven;
   logic [2:0]        sh_pol;
   logic [COL_W-1:0]  sh_bord, sh_uf;
   logic [LINE_W-1:0] line_q;

   pxtg_regs #(.H_W(H_W), .CNT_W(CNT_W), .COL_W(COL_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .frame_load(frame_load), .tg_en(tg_en),
      .cnt_en(cnt_en), .per(per), .pr_hper(pr_hper), .pr_skew(pr_skew),
      .sh_hper(sh_hper), .sh_hsw(sh_hsw), .sh_dhs(sh_dhs), .sh_dhe(sh_dhe),
      .sh_vsw(sh_vsw), .sh_dvs(sh_dvs), .sh_dve(sh_dve), .sh_ahen(sh_ahen),
      .sh_ahs(sh_ahs), .sh_ahe(sh_ahe), .sh_aven(sh_aven), .sh_avs(sh_avs),
      .sh_ave(sh_ave), .sh_pol(sh_pol), .sh_bord(sh_bord), .sh_uf(sh_uf)
   );

   pxtg_counters #(.H_W(H_W), .CNT_W(CNT_W), .LINE_W(LINE_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tg_en(tg_en), .count_frames(cnt_en[1]),
      .per(per), .sh_hper(sh_hper), .pr_hper(pr_hper), .pr_skew(pr_skew),
      .fcnt(fcnt), .hcnt(hcnt), .line_q(line_q), .frames_q(frame_count),
      .frame_load(frame_load), .frame_start(frame_start)
   );

   pxtg_window #(.H_W(H_W), .CNT_W(CNT_W), .COL_W(COL_W),
                 .HAS_SUBWIN(HAS_SUBWIN)) u_win (
      .clk(clk), .rst_n(rst_n), .tg_en(tg_en), .fcnt(fcnt), .hcnt(hcnt),
      .sh_hsw(sh_hsw), .sh_dhs(sh_dhs), .sh_dhe(sh_dhe), .sh_vsw(sh_vsw),
      .sh_dvs(sh_dvs), .sh_dve(sh_dve), .sh_ahen(sh_ahen), .sh_ahs(sh_ahs),
      .sh_ahe(sh_ahe), .sh_aven(sh_aven), .sh_avs(sh_avs), .sh_ave(sh_ave),
      .sh_pol(sh_pol), .sh_bord(sh_bord), .sh_uf(sh_uf), .pix_in(pix_in),
      .pix_valid(pix_valid), .hsync(hsync), .vsync(vsync), .de(de),
      .pix_req(pix_req), .pix_out(pix_out), .underflow(underflow)
   );

   assign line_count = cnt_en[0] ? line_q : '0;

   // R9
   idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tg_en |-> (!pix_req && pix_out == '0 && !frame_start && !underflow));

   // R3
   line_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> (line_count == '0));

endmodule

// File: tb/pxtg_top_bench.sv
module pxtg_top_bench;
   import pxtg_pkg::*;

   localparam int COL_W  = 24;
   localparam int LINE_W = 16;
   localparam int HM = 32'h7FFF;
   localparam int CM = 32'h7FFFFF;
   localparam int LM = 32'hFFFF;
   localparam int KM = 32'hFFFFFF;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [3:0]        wr_addr = '0;
   logic [31:0]       wr_data = '0;
   logic [COL_W-1:0]  pix_in = '0;
   logic              pix_valid = 1'b0;
   logic              hsync, vsync, de, pix_req, underflow, frame_start;
   logic [COL_W-1:0]  pix_out;
   logic [LINE_W-1:0] line_count, frame_count;

   pxtg_top u_pxtg_top (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .pix_in(pix_in), .pix_valid(pix_valid),
      .hsync(hsync), .vsync(vsync), .de(de), .pix_req(pix_req),
      .pix_out(pix_out), .underflow(underflow), .frame_start(frame_start),
      .line_count(line_count), .frame_count(frame_count)
   );

   always #5 clk = ~clk;

   int n_chk = 0;
   int n_err = 0;
   bit cmp_on = 1'b0;
   bit uf_mode = 1'b0;
   bit done = 1'b0;
   int cyc = 0;

   // behavioural model state
   int m_hper, m_hsw, m_dhs, m_dhe, m_vsw, m_dvs, m_dve, m_ahs, m_ahe;
   int m_avs, m_ave, m_skew, m_pol, m_bord, m_uf, m_cnten, m_per;
   bit m_ahen, m_aven, m_en;
   int s_hper, s_hsw, s_dhs, s_dhe, s_vsw, s_dvs, s_dve, s_ahs, s_ahe;
   int s_avs, s_ave, s_pol, s_bord, s_uf;
   bit s_ahen, s_aven;
   int fc, hc, ln, frc, rl;

   task automatic check(string tag, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic copy_shadow();
      s_hper = m_hper; s_hsw = m_hsw; s_dhs = m_dhs; s_dhe = m_dhe;
      s_vsw = m_vsw; s_dvs = m_dvs; s_dve = m_dve; s_ahen = m_ahen;
      s_ahs = m_ahs; s_ahe = m_ahe; s_aven = m_aven; s_avs = m_avs;
      s_ave = m_ave; s_pol = m_pol; s_bord = m_bord; s_uf = m_uf;
   endtask

   task automatic model_reset();
      m_hper = 0; m_hsw = 0; m_dhs = 0; m_dhe = 0; m_vsw = 0; m_dvs = 0;
      m_dve = 0; m_ahen = 0; m_ahs = 0; m_ahe = 0; m_aven = 0; m_avs = 0;
      m_ave = 0; m_skew = 0; m_pol = 0; m_bord = 0; m_uf = 0; m_cnten = 0;
      m_per = 0; m_en = 0;
      copy_shadow();
      fc = 0; hc = 0; ln = 0; frc = 0;
   endtask

   initial model_reset();

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         model_reset();
      end else begin
         rl = (m_skew == 0) ? 0 : ((m_hper - m_skew) & HM);
         if (!m_en) begin
            copy_shadow(); fc = 0; hc = rl; ln = 0; frc = 0;
         end else if (fc + 1 >= m_per) begin
            copy_shadow(); fc = 0; hc = rl; ln = 0;
            if (m_cnten[1]) frc = (frc + 1) & LM;
         end else begin
            fc = fc + 1;
            if (hc + 1 >= s_hper) begin
               hc = 0; ln = (ln + 1) & LM;
            end else begin
               hc = hc + 1;
            end
         end
         if (wr_en) begin
            case (wr_addr)
               A_HCTL:  begin m_hper = int'(wr_data[30:16]); m_hsw = int'(wr_data[14:0]); end
               A_VPER:  if (!wr_data[23]) m_per = int'(wr_data[22:0]);
               A_VSW:   m_vsw = int'(wr_data[22:0]);
               A_DISPH: begin m_dhs = int'(wr_data[14:0]); m_dhe = int'(wr_data[30:16]); end
               A_DVS:   m_dvs = int'(wr_data[22:0]);
               A_DVE:   m_dve = int'(wr_data[22:0]);
               A_ACTH:  begin m_ahen = wr_data[31]; m_ahs = int'(wr_data[14:0]); m_ahe = int'(wr_data[30:16]); end
               A_AVS:   begin m_aven = wr_data[31]; m_avs = int'(wr_data[22:0]); end
               A_AVE:   m_ave = int'(wr_data[22:0]);
               A_SKEW:  m_skew = int'(wr_data[14:0]);
               A_POL:   m_pol = int'(wr_data[2:0]);
               A_BORD:  m_bord = int'(wr_data[23:0]);
               A_UFCOL: m_uf = int'(wr_data[23:0]);
               A_CNTEN: m_cnten = int'(wr_data[1:0]);
               A_TGEN:  m_en = wr_data[0];
               default: ;
            endcase
         end
      end
   end

   task automatic compare_all();
      bit hsr, vsr, disp, act;
      int px;
      hsr  = m_en && (hc < s_hsw);
      vsr  = m_en && (fc < s_vsw);
      disp = m_en && fc >= s_dvs && fc <= s_dve && hc >= s_dhs && hc <= s_dhe;
      act  = disp && (!s_ahen || (hc >= s_ahs && hc <= s_ahe))
                  && (!s_aven || (fc >= s_avs && fc <= s_ave));
      if (!disp)          px = 0;
      else if (!act)      px = s_bord;
      else if (pix_valid) px = int'(pix_in);
      else                px = s_uf;
      check("R4 R8 hsync", hsync, hsr ^ s_pol[0]);
      check("R4 R8 vsync", vsync, vsr ^ s_pol[1]);
      check("R5 R8 de", de, disp ^ s_pol[2]);
      check("R6 pix_req", pix_req, act);
      check("R7 R6 pix_out", pix_out, px & KM);
      check("R7 underflow", underflow, act && !pix_valid);
      check("R2 frame_start", frame_start, m_en && fc == 0);
      check("R3 line_count", line_count, m_cnten[0] ? ln : 0);
      check("R3 frame_count", frame_count, frc);
   endtask

   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (cmp_on) compare_all();
      end
   end

   initial begin
      forever begin
         @(negedge clk);
         cyc++;
         pix_in    = COL_W'((cyc * 32'h1357) ^ 32'h00A5A5);
         pix_valid = !(uf_mode && ((cyc % 7) < 2));
      end
   end

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      #1;
   endtask

   task automatic wait_fs();
      do begin @(negedge clk); #1; end while (!frame_start);
   endtask

   task automatic measure(output int len);
      wait_fs();
      len = 0;
      do begin @(negedge clk); #1; len++; end while (!frame_start);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog expired before the scenario ended");
      finish_run();
   end

   initial begin
      int len;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      // R12 reset state
      check("R12 hsync", hsync, 0);
      check("R12 vsync", vsync, 0);
      check("R12 de", de, 0);
      check("R12 pix_out", pix_out, 0);
      check("R12 line_count", line_count, 0);
      check("R12 frame_count", frame_count, 0);
      check("R12 frame_start", frame_start, 0);
      cmp_on = 1'b1;

      // R1 base timing: 20-pixel lines, 7 lines, display x 5..16, count 40..119
      wr(A_HCTL, {1'b0, 15'd20, 1'b0, 15'd2});
      wr(A_VPER, 32'd140);
      wr(A_VSW, 32'd20);
      wr(A_DISPH, {1'b0, 15'd16, 1'b0, 15'd5});
      wr(A_DVS, 32'd40);
      wr(A_DVE, 32'd119);
      wr(A_BORD, 32'hB0B0B0);
      wr(A_UFCOL, 32'hEEEE00);
      wr(A_CNTEN, 32'd3);
      wr(A_TGEN, 32'd1);
      // R9 enable starts a frame at once
      check("R9 frame_start after enable", frame_start, 1);
      repeat (300) @(negedge clk);

      // R7 underflow bursts
      uf_mode = 1'b1;
      repeat (200) @(negedge clk);

      // R10 mid-frame polarity write deferred
      wait_fs();
      wr(A_POL, 32'd1);
      check("R10 hsync keeps old polarity mid-frame", hsync, 0);

      // R6 sub-window, skew and shifted window
      wr(A_SKEW, 32'd4);
      wr(A_ACTH, 32'h8000_0000 | (32'd12 << 16) | 32'd7);
      wr(A_AVS, 32'h8000_0000 | 32'd60);
      wr(A_AVE, 32'd99);
      wr(A_DVS, 32'd44);
      wr(A_DVE, 32'd123);
      wr(A_POL, 32'd5);
      repeat (450) @(negedge clk);

      // R11 held period writes leave the frame length alone
      wr(A_VPER, 32'h0080_0000 | 32'd140);
      wr(A_VPER, 32'h0080_0000 | 32'd160);
      measure(len);
      check("R11 held period frame length", len, 140);
      wr(A_VPER, 32'd160);
      measure(len);
      check("R11 committed period frame length", len, 160);

      // R1 R3 line count gated by counter-enable bit 0
      wr(A_CNTEN, 32'd2);
      repeat (30) @(negedge clk);
      check("R1 R3 line_count gated", line_count, 0);
      wr(A_CNTEN, 32'd3);
      repeat (100) @(negedge clk);

      // R9 disable then restart
      wr(A_TGEN, 32'd0);
      check("R9 idle pix_req", pix_req, 0);
      check("R9 idle pix_out", pix_out, 0);
      @(negedge clk); #1;
      check("R9 idle line_count", line_count, 0);
      check("R9 idle frame_count", frame_count, 0);
      repeat (20) @(negedge clk);
      wr(A_TGEN, 32'd1);
      check("R9 frame_start after re-enable", frame_start, 1);
      repeat (250) @(negedge clk);

      finish_run();
   end

endmodule